// File: doc/BRIEF.md
# LCD Frame Timer and Display Latch

This block derives the LCD frame timing from a free-running oscillator clock. It also holds the segment data that the output drivers show. A fixed divide of the oscillator clock sets the frame period. The frame is cut into equal time slots, one per active backplane, and each slot has two half-phases of opposite polarity so that the drive carries no DC component. A one-cycle strobe marks each frame boundary and each half-frame boundary. On those strobes the display latch copies the full serial shift-register word, but only when no serial transfer is under way.

After reset the block stays asleep. It counts nothing and emits no strobes until the serial interface reports its wake event, its first rising serial clock edge. From then on the timer runs without stopping. All pins are plain level or pulse signals. There is no data stream with back-pressure here: the shift-register word is sampled whenever a capture is allowed, and the latch outputs are always valid.

Top module: `lcd_frame_latch`

## Requirements
- R1: After reset, `disp_bits` is all zero, `frame_stb` and `half_stb` are low, and `slot_idx` and `half_phase` are 0.
- R2: Until `wake` has been sampled high, no strobe fires, `slot_idx` stays 0 and `disp_bits` keeps its reset value. One sampled `wake` pulse starts the timer for good, and `wake` going low again has no effect.
- R3: `frame_stb` first rises FRAME_DIV clock edges after the edge that samples `wake`. After that it pulses for one cycle every FRAME_DIV cycles, in every drive mode.
- R4: `half_stb` pulses for one cycle exactly FRAME_DIV/2 cycles after each frame start, and never in the same cycle as `frame_stb`.
- R5: `mode` encodes the number of slots as follows: 2'b01 gives 1 slot, 2'b10 gives 2 slots and 2'b11 gives 3 slots. With n slots, each slot lasts FRAME_DIV/n cycles, and `half_phase` is 0 for the first half of the slot and 1 for the second. Counting from the frame start, after k cycles `slot_idx` = floor(k/(FRAME_DIV/(2n))) div 2 and `half_phase` is the same quotient mod 2.
- R6: While running, `mode` is sampled only at frame boundaries. A change in mid-frame takes effect at the next frame start.
- R7: When a strobe (`frame_stb` or `half_stb`) is high and `ser_en` is low, `disp_bits` takes `shift_data` at the next clock edge. At no other time does `disp_bits` change, whatever `shift_data` does.
- R8: While `ser_en` is high, `disp_bits` is frozen. After `ser_en` falls, new data appears one cycle after the next strobe, which is at most FRAME_DIV/2 + 1 cycles later.
- R9: Latch bit i equals shift-register bit i for every i, so a 1 turns display element i on. Bits [31:0] belong to the first backplane, [63:32] to the second and [95:64] to the third.
- R10: `mode` 2'b00 (test setting) is timed as a single slot, the same as 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial transfer in progress; blocks latch capture |
| wake | input | 1 | Wake event from the serial interface |
| mode | input | 2 | Drive mode (slot count) |
| shift_data | input | 96 | Shift-register contents |
| disp_bits | output | 96 | Latched display bits |
| frame_stb | output | 1 | One-cycle frame boundary strobe |
| half_stb | output | 1 | One-cycle half-frame strobe |
| slot_idx | output | 2 | Current backplane slot |
| half_phase | output | 1 | Polarity half of the current slot |

## Verification
Every timing result is counted in clock edges from a known reference edge: the edge that samples `wake`, or the edge that raises `frame_stb`. The strobes and the slot/phase pair are registered, so after k edges they show the state of cycle k. The bench samples at the falling edge after edge k and compares against the closed-form slot formula at every cycle of each frame. A capture lands one edge after the strobe, so the bench checks that the old word is still present in the strobe cycle and the new word one cycle later. The freeze case measures the exact delay from the fall of `ser_en` to the latch change.

// File: rtl/lcdft_pkg.sv
package lcdft_pkg;
  localparam int unsigned BP_MAX = 3;

  typedef enum logic [1:0] {
    DRV_TEST    = 2'b00,
    DRV_STATIC  = 2'b01,
    DRV_DUPLEX  = 2'b10,
    DRV_TRIPLEX = 2'b11
  } drive_mode_e;

  // number of active backplane slots for a drive mode
  function automatic logic [1:0] slots_of(input logic [1:0] m);
    case (m)
      DRV_DUPLEX:  slots_of = 2'd2;
      DRV_TRIPLEX: slots_of = 2'd3;
      default:     slots_of = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/lcdft_wake_gate.sv
module lcdft_wake_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  output logic running
);
  // sticky: once woken the timer never stops until reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    running <= 1'b0;
    else if (wake) running <= 1'b1;
  end
endmodule

// File: rtl/lcdft_frame_timer.sv
module lcdft_frame_timer
  import lcdft_pkg::*;
#(
  parameter int unsigned FRAME_DIV = 2400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  logic [1:0] mode,
  output logic       frame_stb,
  output logic       half_stb,
  output logic [1:0] slot,
  output logic       polarity
);
  localparam int unsigned CNT_W = $clog2(FRAME_DIV);
  localparam int unsigned HP_W  = $clog2(2 * BP_MAX);

  logic [CNT_W-1:0] cnt, seg_last;
  logic [HP_W-1:0]  hp, hp_last, hp_half_pre;
  logic [1:0]       act_n;

  // half-slot length picked from constant divisions, no runtime divider
  always_comb begin
    seg_last = CNT_W'(FRAME_DIV / 2 - 1);
    for (int k = 1; k <= int'(BP_MAX); k++) begin
      if (act_n == 2'(k)) seg_last = CNT_W'(FRAME_DIV / (2 * k) - 1);
    end
    hp_last     = HP_W'({1'b0, act_n, 1'b0} - 4'd1);
    hp_half_pre = HP_W'({2'b00, act_n} - 4'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      hp        <= '0;
      act_n     <= 2'd1;
      frame_stb <= 1'b0;
      half_stb  <= 1'b0;
    end else begin
      frame_stb <= 1'b0;
      half_stb  <= 1'b0;
      if (!running) begin
        act_n <= slots_of(mode);
      end else if (cnt == seg_last) begin
        cnt <= '0;
        if (hp == hp_last) begin
          hp        <= '0;
          frame_stb <= 1'b1;
          act_n     <= slots_of(mode);
        end else begin
          hp <= hp + 1'b1;
          if (hp == hp_half_pre) half_stb <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign slot     = 2'(hp[HP_W-1:1]);
  assign polarity = hp[0];
endmodule

// File: rtl/lcdft_disp_latch.sv
module lcdft_disp_latch #(
  parameter int unsigned SEG_PER_BP = 32,
  parameter int unsigned GROUPS     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_stb,
  input  logic                         ser_en,
  input  logic [SEG_PER_BP*GROUPS-1:0] shift_data,
  output logic [SEG_PER_BP*GROUPS-1:0] disp
);
  logic take;
  assign take = cap_stb & ~ser_en;

  for (genvar g = 0; g < int'(GROUPS); g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        disp[g*SEG_PER_BP +: SEG_PER_BP] <= '0;
      else if (take)
        disp[g*SEG_PER_BP +: SEG_PER_BP] <= shift_data[g*SEG_PER_BP +: SEG_PER_BP];
    end
  end
endmodule

// File: rtl/lcd_frame_latch.sv
module lcd_frame_latch
  import lcdft_pkg::*;
#(
  parameter int unsigned SEG_PER_BP = 32,
  parameter int unsigned FRAME_DIV  = 2400
) (
  input  logic                         clk_osc,
  input  logic                         rst_n,
  input  logic                         ser_en,
  input  logic                         wake,
  input  logic [1:0]                   mode,
  input  logic [SEG_PER_BP*BP_MAX-1:0] shift_data,
  output logic [SEG_PER_BP*BP_MAX-1:0] disp_bits,
  output logic                         frame_stb,
  output logic                         half_stb,
  output logic [1:0]                   slot_idx,
  output logic                         half_phase
);
  logic running;

  lcdft_wake_gate u_wake (
    .clk(clk_osc), .rst_n(rst_n), .wake(wake), .running(running)
  );

  lcdft_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_timer (
    .clk(clk_osc), .rst_n(rst_n), .running(running), .mode(mode),
    .frame_stb(frame_stb), .half_stb(half_stb),
    .slot(slot_idx), .polarity(half_phase)
  );

  lcdft_disp_latch #(.SEG_PER_BP(SEG_PER_BP), .GROUPS(BP_MAX)) u_latch (
    .clk(clk_osc), .rst_n(rst_n), .cap_stb(frame_stb | half_stb),
    .ser_en(ser_en), .shift_data(shift_data), .disp(disp_bits)
  );
endmodule

// File: rtl/lcd_frame_latch_chk.sv
module lcd_frame_latch_chk #(
  parameter int unsigned SEG_PER_BP = 32,
  parameter int unsigned FRAME_DIV  = 2400
) (
  input logic                   clk_osc,
  input logic                   rst_n,
  input logic                   ser_en,
  input logic                   wake,
  input logic [SEG_PER_BP*3-1:0] disp_bits,
  input logic                   frame_stb,
  input logic                   half_stb,
  input logic [1:0]             slot_idx,
  input logic                   half_phase
);
  localparam int unsigned GAP_W = $clog2(FRAME_DIV + 1) + 1;

  logic woke, seen;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      woke <= 1'b0;
      seen <= 1'b0;
      gap  <= '0;
    end else begin
      if (wake) woke <= 1'b1;
      if (frame_stb) begin
        // R3: frame period in cycles
        a_r3_frame_period: assert (!seen || gap == GAP_W'(FRAME_DIV))
          else $error("frame period %0d", gap);
        seen <= 1'b1;
        gap  <= GAP_W'(1);
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  a_r2_asleep_quiet: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !woke |-> (!frame_stb && !half_stb && slot_idx == 2'd0));
  a_r4_strobes_exclusive: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !(frame_stb && half_stb));
  a_r5_frame_starts_slot0: assert property (@(posedge clk_osc) disable iff (!rst_n)
    frame_stb |-> (slot_idx == 2'd0 && !half_phase));
  a_r5_slot_range: assert property (@(posedge clk_osc) disable iff (!rst_n)
    slot_idx < 2'd3);
  a_r7_change_on_strobe: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !(frame_stb || half_stb) |=> $stable(disp_bits));
  a_r8_frozen_in_transfer: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ser_en |=> $stable(disp_bits));
endmodule

bind lcd_frame_latch lcd_frame_latch_chk #(
  .SEG_PER_BP(SEG_PER_BP), .FRAME_DIV(FRAME_DIV)
) u_chk (
  .clk_osc(clk_osc), .rst_n(rst_n), .ser_en(ser_en), .wake(wake),
  .disp_bits(disp_bits), .frame_stb(frame_stb), .half_stb(half_stb),
  .slot_idx(slot_idx), .half_phase(half_phase)
);

// File: tb/test_lcd_frame_latch.sv
module test_lcd_frame_latch;
  localparam int FDIV = 2400;
  localparam int W    = 96;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_en;
  logic         wake;
  logic [1:0]   mode;
  logic [W-1:0] shift_data;
  logic [W-1:0] disp_bits;
  logic         frame_stb, half_stb, half_phase;
  logic [1:0]   slot_idx;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lcd_frame_latch #(.SEG_PER_BP(32), .FRAME_DIV(FDIV)) i_lcd_frame_latch (
    .clk_osc(clk), .rst_n(rst_n), .ser_en(ser_en), .wake(wake), .mode(mode),
    .shift_data(shift_data), .disp_bits(disp_bits), .frame_stb(frame_stb),
    .half_stb(half_stb), .slot_idx(slot_idx), .half_phase(half_phase)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  // Starts at a negedge with j=0 (frame start); walks one whole frame.
  task automatic run_frame(input int n, input string tag, input int chg_j, input logic [1:0] new_mode);
    int seg, bad_slot, bad_stb, hp;
    seg = FDIV / (2 * n);
    bad_slot = 0; bad_stb = 0;
    for (int j = 1; j <= FDIV; j++) begin
      @(negedge clk);
      hp = (j / seg) % (2 * n);
      if (slot_idx != 2'(hp / 2) || half_phase != 1'(hp % 2)) bad_slot++;
      if (frame_stb != (j == FDIV) || half_stb != (j == FDIV / 2)) bad_stb++;
      if (j == chg_j) mode = new_mode;
    end
    chk(bad_slot == 0, {tag, " R5 slot/phase pattern"}, W'(bad_slot), '0);
    chk(bad_stb == 0, {tag, " R3 R4 strobe timing"}, W'(bad_stb), '0);
  endtask

  task automatic wait_frame();
    for (int i = 0; i < 3 * FDIV; i++) begin
      @(negedge clk);
      if (frame_stb) return;
    end
  endtask

  task automatic t_reset();
    chk(disp_bits == '0, "R1 disp after reset", disp_bits, '0);
    chk({frame_stb, half_stb, slot_idx, half_phase} == '0, "R1 timing outputs after reset",
        W'({frame_stb, half_stb, slot_idx, half_phase}), '0);
  endtask

  task automatic t_sleep();
    int bad;
    bad = 0;
    shift_data = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0};
    ser_en = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (frame_stb || half_stb || slot_idx != 2'd0 || disp_bits != '0) bad++;
    end
    chk(bad == 0, "R2 asleep: no strobes, slot 0, latch untouched", W'(bad), '0);
  endtask

  task automatic t_wake();
    mode = 2'b11;
    wake = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake = 1'b0;  // R2: pulse is enough, timer keeps running
    run_frame(3, "R3 first frame after wake triplex", -1, 2'b11);
    chk(disp_bits == shift_data, "R7 half-frame capture in first frame", disp_bits, shift_data);
  endtask

  task automatic t_capture();
    logic [W-1:0] p0, p1;
    p0 = shift_data;
    p1 = {32'h0000_0001, 32'h8000_0000, 32'hA5C3_0F96};
    shift_data = p1;
    chk(disp_bits == p0, "R7 old word still shown in strobe cycle", disp_bits, p0);
    @(negedge clk);
    chk(disp_bits == p1, "R9 bit-exact capture one cycle after strobe", disp_bits, p1);
    shift_data = ~p1;
    repeat (100) @(negedge clk);
    chk(disp_bits == p1, "R7 shift word change between strobes ignored", disp_bits, p1);
  endtask

  task automatic t_freeze();
    logic [W-1:0] p1, p3;
    int d;
    p1 = disp_bits;
    p3 = {32'hDEAD_BEEF, 32'h0000_FFFF, 32'h1357_9BDF};
    ser_en = 1'b1;
    shift_data = p3;
    // now j=101; half strobe at j=1200 must not capture
    repeat (1200) @(negedge clk);
    chk(disp_bits == p1, "R8 frozen across half strobe while enabled", disp_bits, p1);
    // j=1301; drop enable at j=1500, next strobe at j=2400, capture visible j=2401
    repeat (199) @(negedge clk);
    ser_en = 1'b0;
    d = 0;
    for (int i = 0; i < FDIV; i++) begin
      @(negedge clk);
      d++;
      if (disp_bits == p3) break;
    end
    chk(disp_bits == p3, "R8 new word after enable falls", disp_bits, p3);
    chk(d == 901 && d <= FDIV / 2 + 1, "R8 delay from enable fall to update", W'(d), W'(901));
    wait_frame();
  endtask

  task automatic t_modes();
    run_frame(3, "R6 triplex frame with mid-frame change", 700, 2'b10);
    run_frame(2, "R6 duplex frame after boundary", 1000, 2'b01);
    run_frame(1, "R5 static frame", 300, 2'b00);
    run_frame(1, "R10 test-setting frame as one slot", 500, 2'b11);
    run_frame(3, "R5 triplex frame again", -1, 2'b11);
  endtask

  initial begin
    rst_n = 1'b0;
    ser_en = 1'b0;
    wake = 1'b0;
    mode = 2'b11;
    shift_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sleep();
    t_wake();
    t_capture();
    t_freeze();
    t_modes();
    finish_run();
  end
endmodule